// File: doc/BRIEF.md
# Low-Power Mode Entry and Wake Controller

This block decides which reduced-power state the system enters when the processor issues a wait instruction, and which events may return it to normal running. The requested depth is selected by a two-bit mode code together with a separate deep-sleep flag. A single-cycle sleep-request strobe from the processor triggers the selection. The block keeps the current state as a one-hot vector and decodes it into clock-gate and power-gate enables for the rest of the chip.

Each low-power state accepts its own set of wake sources. Plain sleep wakes on any enabled interrupt. The two intermediate states wake only on enabled interrupts that also fall in a wake-capable mask. The watchdog is accepted in deep sleep only while it runs from the internal RC oscillator. The deepest state keeps no internal context, so it can be left only through an external reset or an enabled RTC interrupt. In both cases it restarts as if from reset.

Top module: `lpm_ctrl`

## Requirements
- R1: With mode code 00, a sleep request in run enters Sleep when the deep-sleep flag is 0 and Deep Sleep when it is 1.
- R2: With mode code 01, a sleep request enters Power-down when the deep-sleep flag is 1 and Sleep when it is 0.
- R3: With mode code 11, a sleep request enters Deep Power-down when the deep-sleep flag is 1 and Sleep when it is 0.
- R4: With mode code 10, a sleep request is ignored and the block stays in run, whatever the deep-sleep flag.
- R5: In Sleep, any pending interrupt whose enable bit is set causes a wake; pending interrupts that are not enabled do not.
- R6: In Deep Sleep and Power-down, only a pending interrupt that is both enabled and set in the wake-capable mask, or an enabled RTC interrupt, causes a wake.
- R7: The enabled watchdog interrupt wakes Deep Sleep only while the watchdog-on-RC flag is 1, and never wakes Power-down.
- R8: Deep Power-down is left only on external reset or on an enabled RTC interrupt. Either exit returns to run in the reset state, with no wake pulse.
- R9: A wake from Sleep, Deep Sleep or Power-down puts the block in run and reasserts all enables in the same cycle as the state change. It also raises wake_pulse for exactly that one cycle.
- R10: If a source that would wake the target state is already pending when the sleep request arrives, the block stays in run.
- R11: State encoding is state_oh bit 0 run, bit 1 Sleep, bit 2 Deep Sleep, bit 3 Power-down, bit 4 Deep Power-down, and exactly one bit is set. cpu_clk_en is 1 only in run. bus_clk_en is 1 in run and Sleep. osc_pwr_en is 1 in run, Sleep and Deep Sleep. core_pwr_en is 1 in every state except Deep Power-down.
- R12: A sleep request that arrives while the block is not in run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| mode_code | input | 2 | Requested low-power depth code |
| deep_flag | input | 1 | Deep-sleep selector from the processor |
| sleep_req | input | 1 | Wait-instruction strobe |
| irq_pend | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Interrupt enable bits |
| wake_cap | input | NUM_IRQ | Mask of interrupts able to wake deep states |
| wdt_irq | input | 1 | Watchdog interrupt request |
| wdt_en | input | 1 | Watchdog interrupt enable |
| wdt_on_irc | input | 1 | Watchdog is clocked from the internal RC oscillator |
| rtc_irq | input | 1 | RTC interrupt request |
| rtc_en | input | 1 | RTC interrupt enable |
| state_oh | output | 5 | One-hot current state |
| cpu_clk_en | output | 1 | Processor clock enable |
| bus_clk_en | output | 1 | Bus and peripheral clock enable |
| osc_pwr_en | output | 1 | Main oscillator and flash power enable |
| core_pwr_en | output | 1 | Core domain power enable |
| wake_pulse | output | 1 | One-cycle pulse on a wake into run |

## Verification
The hardest case to reach is a state that must refuse a wake: an interrupt that is pending but not wake-capable, or a watchdog that is not running from the RC oscillator. The bench has to place the block in the deep state first, with every would-be wake source quiet so that the entry is not blocked. It then raises the refused source and holds it for several cycles while watching the one-hot state. Only after that does it add a legitimate source, which shows that the block was still responsive. The pending-at-entry case is reached the opposite way: the interrupt is raised before the strobe, so that the entry is blocked.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
   localparam int ST_W = 5;
   typedef enum logic [ST_W-1:0] {
      ST_RUN   = 5'b00001,
      ST_SLEEP = 5'b00010,
      ST_DSLP  = 5'b00100,
      ST_PDN   = 5'b01000,
      ST_DPD   = 5'b10000
   } lpm_state_e;

   localparam logic [1:0] CODE_BASE = 2'b00;
   localparam logic [1:0] CODE_PDN  = 2'b01;
   localparam logic [1:0] CODE_RSVD = 2'b10;
   localparam logic [1:0] CODE_DPD  = 2'b11;
endpackage

// File: rtl/lpm_mode_decode.sv
`timescale 1ns/1ps
module lpm_mode_decode
   import lpm_pkg::*;
(
   input  logic [1:0]  mode_code,
   input  logic        deep_flag,
   output lpm_state_e  target,
   output logic        target_ok
);
   always_comb begin
      target    = ST_RUN;
      target_ok = 1'b1;
      case (mode_code)
         CODE_BASE: target = deep_flag ? ST_DSLP : ST_SLEEP;
         CODE_PDN:  target = deep_flag ? ST_PDN  : ST_SLEEP;
         CODE_DPD:  target = deep_flag ? ST_DPD  : ST_SLEEP;
         default:   target_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/lpm_wake_qual.sv
`timescale 1ns/1ps
module lpm_wake_qual #(
   parameter int NUM_IRQ       = 16,
   parameter bit WDT_DEEP_WAKE = 1'b1
) (
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [NUM_IRQ-1:0] wake_cap,
   input  logic               wdt_irq,
   input  logic               wdt_en,
   input  logic               wdt_on_irc,
   input  logic               rtc_irq,
   input  logic               rtc_en,
   output logic               wk_sleep,
   output logic               wk_dslp,
   output logic               wk_pdn,
   output logic               wk_dpd
);
   logic [NUM_IRQ-1:0] live;
   logic               rtc_live, wdt_live, wdt_deep;

   assign live     = irq_pend & irq_en;
   assign rtc_live = rtc_irq & rtc_en;
   assign wdt_live = wdt_irq & wdt_en;

   generate
      if (WDT_DEEP_WAKE) begin : g_wdt_deep
         assign wdt_deep = wdt_live & wdt_on_irc;
      end else begin : g_wdt_none
         assign wdt_deep = 1'b0;
      end
   endgenerate

   assign wk_sleep = (|live) | wdt_live | rtc_live;
   assign wk_pdn   = (|(live & wake_cap)) | rtc_live;
   assign wk_dslp  = wk_pdn | wdt_deep;
   assign wk_dpd   = rtc_live;
endmodule

// File: rtl/lpm_gate_decode.sv
`timescale 1ns/1ps
module lpm_gate_decode
   import lpm_pkg::*;
(
   input  lpm_state_e state,
   output logic       cpu_clk_en,
   output logic       bus_clk_en,
   output logic       osc_pwr_en,
   output logic       core_pwr_en
);
   always_comb begin
      cpu_clk_en  = (state == ST_RUN);
      bus_clk_en  = (state == ST_RUN) || (state == ST_SLEEP);
      osc_pwr_en  = (state == ST_RUN) || (state == ST_SLEEP) || (state == ST_DSLP);
      core_pwr_en = (state != ST_DPD);
   end
endmodule

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int NUM_IRQ       = 16,
   parameter bit WDT_DEEP_WAKE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_code,
   input  logic               deep_flag,
   input  logic               sleep_req,
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic [NUM_IRQ-1:0] wake_cap,
   input  logic               wdt_irq,
   input  logic               wdt_en,
   input  logic               wdt_on_irc,
   input  logic               rtc_irq,
   input  logic               rtc_en,
   output logic [4:0]         state_oh,
   output logic               cpu_clk_en,
   output logic               bus_clk_en,
   output logic               osc_pwr_en,
   output logic               core_pwr_en,
   output logic               wake_pulse
);
   generate
      if (NUM_IRQ < 1 || NUM_IRQ > 256) begin : g_bad_num_irq
         $error("lpm_ctrl: NUM_IRQ out of range 1..256");
      end
   endgenerate

   lpm_state_e state_q;
   lpm_state_e target;
   logic       target_ok, entry_blocked;
   logic       wk_sleep, wk_dslp, wk_pdn, wk_dpd;

   lpm_mode_decode u_mode (
      .mode_code (mode_code),
      .deep_flag (deep_flag),
      .target    (target),
      .target_ok (target_ok)
   );

   lpm_wake_qual #(.NUM_IRQ(NUM_IRQ), .WDT_DEEP_WAKE(WDT_DEEP_WAKE)) u_wake (
      .irq_pend   (irq_pend),
      .irq_en     (irq_en),
      .wake_cap   (wake_cap),
      .wdt_irq    (wdt_irq),
      .wdt_en     (wdt_en),
      .wdt_on_irc (wdt_on_irc),
      .rtc_irq    (rtc_irq),
      .rtc_en     (rtc_en),
      .wk_sleep   (wk_sleep),
      .wk_dslp    (wk_dslp),
      .wk_pdn     (wk_pdn),
      .wk_dpd     (wk_dpd)
   );

   lpm_gate_decode u_gate (
      .state       (state_q),
      .cpu_clk_en  (cpu_clk_en),
      .bus_clk_en  (bus_clk_en),
      .osc_pwr_en  (osc_pwr_en),
      .core_pwr_en (core_pwr_en)
   );

   always_comb begin
      case (target)
         ST_SLEEP: entry_blocked = wk_sleep;
         ST_DSLP:  entry_blocked = wk_dslp;
         ST_PDN:   entry_blocked = wk_pdn;
         ST_DPD:   entry_blocked = wk_dpd;
         default:  entry_blocked = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         wake_pulse <= 1'b0;
      end else begin
         wake_pulse <= 1'b0;
         case (state_q)
            ST_RUN: begin
               if (sleep_req && target_ok && !entry_blocked) state_q <= target;
            end
            ST_SLEEP: if (wk_sleep) begin state_q <= ST_RUN; wake_pulse <= 1'b1; end
            ST_DSLP:  if (wk_dslp)  begin state_q <= ST_RUN; wake_pulse <= 1'b1; end
            ST_PDN:   if (wk_pdn)   begin state_q <= ST_RUN; wake_pulse <= 1'b1; end
            ST_DPD:   if (wk_dpd)   state_q <= ST_RUN;
            default:  state_q <= ST_RUN;
         endcase
      end
   end

   assign state_oh = state_q;

   a_r11_onehot_state: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_oh) == 1);

   a_r4_reserved_code_stays_run: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh == ST_RUN && sleep_req && mode_code == CODE_RSVD) |=> state_oh == ST_RUN);

   a_r8_dpd_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh == ST_DPD && !(rtc_irq && rtc_en)) |=> state_oh == ST_DPD);

   a_r8_dpd_exit_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh == ST_DPD) |=> !wake_pulse);

   a_r9_pulse_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (cpu_clk_en && bus_clk_en && osc_pwr_en && core_pwr_en
                      && $past(state_oh) != ST_RUN));

   a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   a_r7_wdt_no_pdn_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh == ST_PDN && !(|(irq_pend & irq_en & wake_cap)) && !(rtc_irq && rtc_en))
      |=> state_oh == ST_PDN);

   a_r12_req_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh == ST_SLEEP && !wk_sleep) |=> state_oh == ST_SLEEP);
endmodule

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;
   localparam int N = 16;
   localparam logic [4:0] S_RUN = 5'b00001, S_SLP = 5'b00010, S_DSL = 5'b00100,
                          S_PDN = 5'b01000, S_DPD = 5'b10000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] mode_code = 2'b00;
   logic deep_flag = 1'b0, sleep_req = 1'b0;
   logic [N-1:0] irq_pend = '0, irq_en = '1, wake_cap = 16'h00FF;
   logic wdt_irq = 1'b0, wdt_en = 1'b1, wdt_on_irc = 1'b0, rtc_irq = 1'b0, rtc_en = 1'b0;
   logic [4:0] state_oh;
   logic cpu_clk_en, bus_clk_en, osc_pwr_en, core_pwr_en, wake_pulse;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   lpm_ctrl #(.NUM_IRQ(N)) dut (
      .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .deep_flag(deep_flag),
      .sleep_req(sleep_req), .irq_pend(irq_pend), .irq_en(irq_en), .wake_cap(wake_cap),
      .wdt_irq(wdt_irq), .wdt_en(wdt_en), .wdt_on_irc(wdt_on_irc),
      .rtc_irq(rtc_irq), .rtc_en(rtc_en), .state_oh(state_oh),
      .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .osc_pwr_en(osc_pwr_en),
      .core_pwr_en(core_pwr_en), .wake_pulse(wake_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic request(input logic [1:0] code, input logic flag);
      mode_code = code; deep_flag = flag; sleep_req = 1'b1;
      step();
      sleep_req = 1'b0;
   endtask

   task automatic gates(input string req, input logic [3:0] exp);
      chk(req, {cpu_clk_en, bus_clk_en, osc_pwr_en, core_pwr_en}, exp);
   endtask

   task automatic wake_bit(input string req, input int b);
      irq_pend[b] = 1'b1;
      step();
      chk(req, state_oh, S_RUN);
      chk(req, wake_pulse, 1);
      gates(req, 4'b1111);
      irq_pend[b] = 1'b0;
      step();
      chk(req, wake_pulse, 0);
   endtask

   task automatic t_reset();
      chk("R11 reset state", state_oh, S_RUN);
      gates("R11 reset gates", 4'b1111);
      chk("R9 reset pulse", wake_pulse, 0);
   endtask

   task automatic t_code00();
      request(2'b00, 1'b0);
      chk("R1 code00 flag0", state_oh, S_SLP);
      gates("R11 sleep gates", 4'b0111);
      wake_bit("R9 wake from sleep", 12);
      request(2'b00, 1'b1);
      chk("R1 code00 flag1", state_oh, S_DSL);
      gates("R11 deep sleep gates", 4'b0011);
      wake_bit("R9 wake from deep sleep", 1);
   endtask

   task automatic t_code01();
      request(2'b01, 1'b1);
      chk("R2 code01 flag1", state_oh, S_PDN);
      gates("R11 power-down gates", 4'b0001);
      wake_bit("R6 capable wakes power-down", 2);
      request(2'b01, 1'b0);
      chk("R2 code01 flag0", state_oh, S_SLP);
      wake_bit("R5 wake sleep", 12);
   endtask

   task automatic t_code11();
      request(2'b11, 1'b0);
      chk("R3 code11 flag0", state_oh, S_SLP);
      wake_bit("R5 wake sleep", 13);
      request(2'b11, 1'b1);
      chk("R3 code11 flag1", state_oh, S_DPD);
      gates("R11 deep power-down gates", 4'b0000);
      rst_n = 1'b0; step(); rst_n = 1'b1; step();
      chk("R8 reset exit", state_oh, S_RUN);
   endtask

   task automatic t_code10();
      request(2'b10, 1'b0);
      chk("R4 code10 flag0", state_oh, S_RUN);
      request(2'b10, 1'b1);
      chk("R4 code10 flag1", state_oh, S_RUN);
      step();
      chk("R4 still run", state_oh, S_RUN);
   endtask

   task automatic t_sleep_enable();
      request(2'b00, 1'b0);
      irq_en[12] = 1'b0; irq_pend[12] = 1'b1;
      step(3);
      chk("R5 disabled ignored", state_oh, S_SLP);
      irq_en[12] = 1'b1;
      step();
      chk("R5 enabled wakes", state_oh, S_RUN);
      chk("R9 pulse", wake_pulse, 1);
      irq_pend[12] = 1'b0;
      step();
   endtask

   task automatic t_deep_filter();
      request(2'b00, 1'b1);
      irq_pend[12] = 1'b1;
      step(3);
      chk("R6 non-capable ignored in deep sleep", state_oh, S_DSL);
      irq_en[3] = 1'b0; irq_pend[3] = 1'b1;
      step(2);
      chk("R6 disabled capable ignored", state_oh, S_DSL);
      irq_en[3] = 1'b1;
      step();
      chk("R6 enabled capable wakes", state_oh, S_RUN);
      irq_pend = '0;
      step();
      request(2'b01, 1'b1);
      rtc_en = 1'b1; rtc_irq = 1'b1;
      step();
      chk("R6 rtc wakes power-down", state_oh, S_RUN);
      rtc_irq = 1'b0; rtc_en = 1'b0;
      step();
   endtask

   task automatic t_wdt();
      request(2'b00, 1'b1);
      wdt_on_irc = 1'b0; wdt_irq = 1'b1;
      step(3);
      chk("R7 wdt off rc ignored", state_oh, S_DSL);
      wdt_on_irc = 1'b1;
      step();
      chk("R7 wdt on rc wakes", state_oh, S_RUN);
      wdt_irq = 1'b0;
      step();
      request(2'b01, 1'b1);
      chk("R7 enter power-down", state_oh, S_PDN);
      wdt_irq = 1'b1;
      step(3);
      chk("R7 wdt ignored in power-down", state_oh, S_PDN);
      wdt_irq = 1'b0; wdt_on_irc = 1'b0;
      wake_bit("R6 exit power-down", 0);
   endtask

   task automatic t_dpd_rtc();
      request(2'b11, 1'b1);
      irq_pend[0] = 1'b1; rtc_irq = 1'b1;
      step(3);
      chk("R8 irq and disabled rtc ignored", state_oh, S_DPD);
      irq_pend[0] = 1'b0;
      rtc_en = 1'b1;
      step();
      chk("R8 rtc exit", state_oh, S_RUN);
      chk("R8 no pulse", wake_pulse, 0);
      rtc_irq = 1'b0; rtc_en = 1'b0;
      step();
   endtask

   task automatic t_pending();
      irq_pend[12] = 1'b1;
      request(2'b00, 1'b0);
      chk("R10 pending blocks sleep", state_oh, S_RUN);
      request(2'b00, 1'b1);
      chk("R10 non-capable does not block deep sleep", state_oh, S_DSL);
      irq_pend[12] = 1'b0;
      wake_bit("R6 exit", 1);
      irq_pend[4] = 1'b1;
      request(2'b01, 1'b1);
      chk("R10 capable blocks power-down", state_oh, S_RUN);
      irq_pend[4] = 1'b0;
      rtc_en = 1'b1; rtc_irq = 1'b1;
      request(2'b11, 1'b1);
      chk("R10 rtc blocks deep power-down", state_oh, S_RUN);
      rtc_irq = 1'b0; rtc_en = 1'b0;
      step();
   endtask

   task automatic t_req_outside_run();
      request(2'b00, 1'b0);
      request(2'b00, 1'b1);
      chk("R12 request in sleep ignored", state_oh, S_SLP);
      request(2'b11, 1'b1);
      chk("R12 request in sleep ignored again", state_oh, S_SLP);
      wake_bit("R9 exit", 14);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_code00();
      t_code01();
      t_code11();
      t_code10();
      t_sleep_enable();
      t_deep_filter();
      t_wdt();
      t_dpd_rtc();
      t_pending();
      t_req_outside_run();
      finish_run();
   end
endmodule